// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array Controller

This block puts a one-time-programmable fuse array behind a small byte-wide register bus. The array holds a number of banks, 8 by default, each with a number of byte-wide words, 256 by default. Software picks one fuse with two address registers. The upper one carries the bank and the high row bits. The lower one carries the low row bits and the bit index inside the byte. A write to the control register then starts a single-bit burn or an explicit sense of the whole addressed byte. A burn only runs when a key register holds the unlock value, and software clears the key again after each burn. A status register shows busy, program-done and sense-done. A sticky error register records every rejected or protected access. Two mask registers combine status and error bits into one interrupt line.

Beside the fuse cells sits a shadow copy with one byte per fuse word. It is reachable through a separate address window and can be overridden by software without touching the fuses. Each bank has a protection byte that is sampled while reset is asserted. Bit 0 of that byte protects the bank against burns, bit 1 against reads, and bit 2 against shadow overrides. In this model the fuse cells and the shadow are cleared by reset, and a burn sets the bit in both of them.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After reset every control, status, error, mask, key and sense-data register reads 0x00, and `busy` and `irq` are low.
- R2: Register offsets are 0 control, 1 upper address, 2 lower address, 3 key, 4 status, 5 status mask, 6 error, 7 error mask and 8 sense data. The bank is upper[5:3] and the word is {upper[2:0], lower[7:3]}. The bit is lower[2:0]. The upper address register reads back only its six low bits.
- R3: Writing control with bit 0 set and bit 7 clear, while the key holds 0xAA and the bank is not burn-protected, raises `busy` for exactly (L+1)*16 cycles, where L is control[6:4]. It then sets exactly the addressed fuse bit, in both the fuses and the shadow byte, sets status bit 1, and control bit 0 reads 0 again.
- R4: A burn request while the key is not 0xAA starts no cycle, burns nothing and sets error bit 7.
- R5: A burn request with a valid key on a bank whose protection bit 0 is set starts no cycle, burns nothing and sets error bit 6.
- R6: A control write with bit 7 set ignores bit 0 entirely: no cycle, no error and no burn. Bit 7 and the length field still read back.
- R7: Control bit 3 (with bit 0 clear) senses the addressed byte. `busy` is high for 8 cycles, then sense data (offset 8, read-only) holds the fuse byte and status bit 0 is set. On a bank whose protection bit 1 is set, the request sets error bit 2 and starts no cycle.
- R8: Shadow window addresses have bus_addr[11]=1, bank in [10:8] and word in [7:0]. A write replaces the shadow byte and leaves the fuses unchanged. On a bank whose protection bit 2 is set, the write is dropped and error bit 5 is set.
- R9: A shadow read on a bank whose protection bit 1 is set returns 0x00 and sets error bit 4.
- R10: Status bits 1:0 and error bits 7,6,5,4,2 are write-one-to-clear. The status mask stores bits 1:0, the error mask stores bits 7,6,5,4,2, and writes to sense data are ignored.
- R11: `irq` is high when any of (status[1:0] AND status mask) or (error AND error mask) is non-zero.
- R12: While `busy` is high, control writes are ignored, so a start written during a cycle neither begins a second cycle nor lengthens the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; the protection bytes are sampled while it is low |
| prot_cfg | input | 8*NUM_BANKS | Protection byte per bank, bank b at bits [8b+7:8b] |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, marks a read for its side effects |
| bus_addr | input | 12 | Register offset or shadow window address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| busy | output | 1 | A burn or sense cycle is running |
| irq | output | 1 | Masked status or error pending |

## Verification
The hardest case to reach is a start request that arrives while a long burn is still running. It must be dropped, and it must not shorten or extend the burn already in progress. The bench sets the longest pulse length, 128 cycles, and writes a sense start on the very next cycle. It then checks that the total busy time is unchanged and that no sense-done appears. The protection cases need banks with mixed protection bytes that are fixed at reset, so the bench gives four banks different protection before releasing reset.

// File: rtl/otp_fuse_pkg.sv
`timescale 1ns/1ps
package otp_fuse_pkg;
  typedef enum logic [3:0] {
    RI_FCTL  = 4'd0,
    RI_UA    = 4'd1,
    RI_LA    = 4'd2,
    RI_KEY   = 4'd3,
    RI_STAT  = 4'd4,
    RI_STATM = 4'd5,
    RI_ERR   = 4'd6,
    RI_EMASK = 4'd7,
    RI_SDAT  = 4'd8
  } reg_idx_e;

  localparam logic [7:0] PROG_KEY     = 8'hAA;
  localparam int         SENSE_CYCLES = 8;

  // control bit positions
  localparam int FC_PRG = 0;
  localparam int FC_SNS = 3;
  localparam int FC_DPC = 7;
  // status bit positions
  localparam int ST_SNSD = 0;
  localparam int ST_PRGD = 1;
  localparam int ST_BUSY = 7;
  // error bit positions
  localparam int ER_SNS = 2;
  localparam int ER_RP  = 4;
  localparam int ER_OP  = 5;
  localparam int ER_WP  = 6;
  localparam int ER_PRG = 7;
  localparam logic [7:0] ERR_IMPL = 8'hF4;
  // protection byte bit positions
  localparam int PC_WP = 0;
  localparam int PC_RP = 1;
  localparam int PC_OP = 2;

  function automatic logic [7:0] prog_cycles(input logic [2:0] len);
    return ({5'd0, len} + 8'd1) << 4;
  endfunction

  function automatic logic [2:0] bank_of(input logic [5:0] ua);
    return ua[5:3];
  endfunction

  function automatic logic [7:0] row_of(input logic [5:0] ua, input logic [7:0] la);
    return {ua[2:0], la[7:3]};
  endfunction

  function automatic logic [2:0] bit_of(input logic [7:0] la);
    return la[2:0];
  endfunction
endpackage

// File: rtl/otp_fuse_seq.sv
`timescale 1ns/1ps
module otp_fuse_seq
  import otp_fuse_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       prog_go,
  input  logic       sense_go,
  input  logic [2:0] pulse_len,
  output logic       busy,
  output logic       burn_fire,
  output logic       sense_fire
);
  typedef enum logic [1:0] {SQ_IDLE, SQ_PROG, SQ_SENSE} sq_state_e;

  sq_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       prog_len_cyc;

  assign prog_len_cyc = prog_cycles(pulse_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        SQ_IDLE: begin
          if (prog_go) begin
            state_q <= SQ_PROG;
            cnt_q   <= CNT_W'(prog_len_cyc - 8'd1);
          end else if (sense_go) begin
            state_q <= SQ_SENSE;
            cnt_q   <= CNT_W'(SENSE_CYCLES - 1);
          end
        end
        default: begin
          if (cnt_q == '0) state_q <= SQ_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
      endcase
    end
  end

  assign busy       = (state_q != SQ_IDLE);
  assign burn_fire  = (state_q == SQ_PROG)  && (cnt_q == '0);
  assign sense_fire = (state_q == SQ_SENSE) && (cnt_q == '0);
endmodule

// File: rtl/otp_fuse_array.sv
`timescale 1ns/1ps
module otp_fuse_array #(
  parameter int NUM_BANKS      = 8,
  parameter int WORDS_PER_BANK = 256,
  localparam int DEPTH = NUM_BANKS * WORDS_PER_BANK,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             burn_en,
  input  logic [IDX_W-1:0] tgt_idx,
  input  logic [2:0]       tgt_bit,
  output logic [7:0]       sense_byte,
  input  logic             sh_wr_en,
  input  logic [IDX_W-1:0] sh_idx,
  input  logic [7:0]       sh_wdata,
  output logic [7:0]       sh_rdata
);
  logic [7:0] fuse_q   [DEPTH];
  logic [7:0] shadow_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) fuse_q[i] <= '0;
    end else if (burn_en) begin
      fuse_q[tgt_idx][tgt_bit] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) shadow_q[i] <= '0;
    end else begin
      if (sh_wr_en) shadow_q[sh_idx] <= sh_wdata;
      if (burn_en)  shadow_q[tgt_idx][tgt_bit] <= 1'b1;
    end
  end

  assign sense_byte = fuse_q[tgt_idx];
  assign sh_rdata   = shadow_q[sh_idx];
endmodule

// File: rtl/otp_fuse_regs.sv
`timescale 1ns/1ps
module otp_fuse_regs
  import otp_fuse_pkg::*;
#(
  parameter int NUM_BANKS      = 8,
  parameter int WORDS_PER_BANK = 256,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int WORD_W = $clog2(WORDS_PER_BANK),
  localparam int IDX_W  = BANK_W + WORD_W,
  localparam int ADDR_W = IDX_W + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [8*NUM_BANKS-1:0] prot_cfg,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [7:0]             bus_wdata,
  output logic [7:0]             bus_rdata,
  input  logic                   busy,
  input  logic                   burn_fire,
  input  logic                   sense_fire,
  output logic                   prog_go,
  output logic                   sense_go,
  output logic [2:0]             pulse_len,
  output logic [IDX_W-1:0]       tgt_idx,
  output logic [2:0]             tgt_bit,
  input  logic [7:0]             sense_byte,
  output logic                   sh_wr_en,
  output logic [IDX_W-1:0]       sh_idx,
  output logic [7:0]             sh_wdata,
  input  logic [7:0]             sh_rdata,
  output logic [7:0]             stat_bits,
  output logic [7:0]             err_bits,
  output logic                   irq
);
  // per-bank protection, sampled during reset
  logic [NUM_BANKS-1:0] wp_q, rp_q, op_q;
  logic                 unused_cfg;
  assign unused_cfg = ^prot_cfg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        wp_q[b] <= prot_cfg[8*b + PC_WP];
        rp_q[b] <= prot_cfg[8*b + PC_RP];
        op_q[b] <= prot_cfg[8*b + PC_OP];
      end
    end
  end

  logic [5:0]       ua_q;
  logic [7:0]       la_q, key_q, emask_q, err_q, sdat_q;
  logic [1:0]       statm_q;
  logic [2:0]       len_q, tgt_bit_q;
  logic             dpc_q, prg_run_q, sns_run_q, prgd_q, snsd_q;
  logic [IDX_W-1:0] tgt_idx_q;

  // address decode
  logic             is_sh, reg_wr;
  logic [3:0]       ridx;
  logic [2:0]       bank3;
  logic [7:0]       row8;
  logic [BANK_W-1:0] cur_bank, sh_bank;
  logic [IDX_W-1:0] cur_idx;

  assign is_sh    = bus_addr[ADDR_W-1];
  assign ridx     = bus_addr[3:0];
  assign reg_wr   = bus_wr && !is_sh;
  assign bank3    = bank_of(ua_q);
  assign row8     = row_of(ua_q, la_q);
  assign cur_bank = bank3[BANK_W-1:0];
  assign cur_idx  = {cur_bank, row8[WORD_W-1:0]};
  assign sh_idx   = bus_addr[IDX_W-1:0];
  assign sh_bank  = bus_addr[IDX_W-1:WORD_W];
  assign sh_wdata = bus_wdata;

  logic wr_fctl, wr_stat, wr_err;
  assign wr_fctl = reg_wr && (ridx == RI_FCTL) && !busy;
  assign wr_stat = reg_wr && (ridx == RI_STAT);
  assign wr_err  = reg_wr && (ridx == RI_ERR);

  // start decode; burn takes precedence over sense
  logic prog_req, sense_req, key_ok;
  logic ev_key_err, ev_wp_err, ev_sns_err, ev_rp_err, ev_op_err;

  assign key_ok     = (key_q == PROG_KEY);
  assign prog_req   = wr_fctl && bus_wdata[FC_PRG] && !bus_wdata[FC_DPC];
  assign ev_key_err = prog_req && !key_ok;
  assign ev_wp_err  = prog_req && key_ok && wp_q[cur_bank];
  assign prog_go    = prog_req && key_ok && !wp_q[cur_bank];
  assign sense_req  = wr_fctl && bus_wdata[FC_SNS] && !bus_wdata[FC_PRG];
  assign ev_sns_err = sense_req && rp_q[cur_bank];
  assign sense_go   = sense_req && !rp_q[cur_bank];
  assign pulse_len  = bus_wdata[6:4];

  assign ev_rp_err  = bus_rd && is_sh && rp_q[sh_bank];
  assign ev_op_err  = bus_wr && is_sh && op_q[sh_bank];
  assign sh_wr_en   = bus_wr && is_sh && !op_q[sh_bank];

  logic [7:0] err_set, err_clr;
  always_comb begin
    err_set         = '0;
    err_set[ER_PRG] = ev_key_err;
    err_set[ER_WP]  = ev_wp_err;
    err_set[ER_OP]  = ev_op_err;
    err_set[ER_RP]  = ev_rp_err;
    err_set[ER_SNS] = ev_sns_err;
    err_clr         = wr_err ? bus_wdata : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ua_q      <= '0;
      la_q      <= '0;
      key_q     <= '0;
      statm_q   <= '0;
      emask_q   <= '0;
      dpc_q     <= 1'b0;
      len_q     <= '0;
      prg_run_q <= 1'b0;
      sns_run_q <= 1'b0;
      prgd_q    <= 1'b0;
      snsd_q    <= 1'b0;
      err_q     <= '0;
      sdat_q    <= '0;
      tgt_idx_q <= '0;
      tgt_bit_q <= '0;
    end else begin
      if (reg_wr && ridx == RI_UA)    ua_q    <= bus_wdata[5:0];
      if (reg_wr && ridx == RI_LA)    la_q    <= bus_wdata;
      if (reg_wr && ridx == RI_KEY)   key_q   <= bus_wdata;
      if (reg_wr && ridx == RI_STATM) statm_q <= bus_wdata[1:0];
      if (reg_wr && ridx == RI_EMASK) emask_q <= bus_wdata & ERR_IMPL;
      if (wr_fctl) begin
        dpc_q <= bus_wdata[FC_DPC];
        len_q <= bus_wdata[6:4];
      end
      if (prog_go)        prg_run_q <= 1'b1;
      else if (burn_fire) prg_run_q <= 1'b0;
      if (sense_go)        sns_run_q <= 1'b1;
      else if (sense_fire) sns_run_q <= 1'b0;
      if (prog_go || sense_go) begin
        tgt_idx_q <= cur_idx;
        tgt_bit_q <= bit_of(la_q);
      end
      prgd_q <= (prgd_q && !(wr_stat && bus_wdata[ST_PRGD])) || burn_fire;
      snsd_q <= (snsd_q && !(wr_stat && bus_wdata[ST_SNSD])) || sense_fire;
      err_q  <= (err_q & ~err_clr) | err_set;
      if (sense_fire) sdat_q <= sense_byte;
    end
  end

  assign tgt_idx = tgt_idx_q;
  assign tgt_bit = tgt_bit_q;

  always_comb begin
    stat_bits          = '0;
    stat_bits[ST_BUSY] = busy;
    stat_bits[ST_PRGD] = prgd_q;
    stat_bits[ST_SNSD] = snsd_q;
  end
  assign err_bits = err_q;
  assign irq      = (|({prgd_q, snsd_q} & statm_q)) || (|(err_q & emask_q));

  always_comb begin
    bus_rdata = 8'h00;
    if (is_sh) begin
      bus_rdata = rp_q[sh_bank] ? 8'h00 : sh_rdata;
    end else begin
      case (ridx)
        RI_FCTL:  bus_rdata = {dpc_q, len_q, sns_run_q, 2'b00, prg_run_q};
        RI_UA:    bus_rdata = {2'b00, ua_q};
        RI_LA:    bus_rdata = la_q;
        RI_KEY:   bus_rdata = key_q;
        RI_STAT:  bus_rdata = stat_bits;
        RI_STATM: bus_rdata = {6'd0, statm_q};
        RI_ERR:   bus_rdata = err_q;
        RI_EMASK: bus_rdata = emask_q;
        RI_SDAT:  bus_rdata = sdat_q;
        default:  bus_rdata = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/otp_fuse_ctrl.sv
`timescale 1ns/1ps
module otp_fuse_ctrl #(
  parameter int NUM_BANKS      = 8,
  parameter int WORDS_PER_BANK = 256,
  parameter int CNT_W          = 8,
  localparam int IDX_W  = $clog2(NUM_BANKS) + $clog2(WORDS_PER_BANK),
  localparam int ADDR_W = IDX_W + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [8*NUM_BANKS-1:0] prot_cfg,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [7:0]             bus_wdata,
  output logic [7:0]             bus_rdata,
  output logic                   busy,
  output logic                   irq
);
  // internal events, named for the checker
  logic             prog_go, sense_go, burn_fire, sense_fire;
  logic [2:0]       pulse_len, tgt_bit;
  logic [IDX_W-1:0] tgt_idx, sh_idx;
  logic [7:0]       sense_byte, sh_wdata, sh_rdata, stat_bits, err_bits;
  logic             sh_wr_en;

  otp_fuse_regs #(.NUM_BANKS(NUM_BANKS), .WORDS_PER_BANK(WORDS_PER_BANK)) regs_i (
    .clk(clk), .rst_n(rst_n), .prot_cfg(prot_cfg),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .burn_fire(burn_fire), .sense_fire(sense_fire),
    .prog_go(prog_go), .sense_go(sense_go), .pulse_len(pulse_len),
    .tgt_idx(tgt_idx), .tgt_bit(tgt_bit), .sense_byte(sense_byte),
    .sh_wr_en(sh_wr_en), .sh_idx(sh_idx), .sh_wdata(sh_wdata),
    .sh_rdata(sh_rdata), .stat_bits(stat_bits), .err_bits(err_bits),
    .irq(irq)
  );

  otp_fuse_seq #(.CNT_W(CNT_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .prog_go(prog_go), .sense_go(sense_go),
    .pulse_len(pulse_len), .busy(busy), .burn_fire(burn_fire),
    .sense_fire(sense_fire)
  );

  otp_fuse_array #(.NUM_BANKS(NUM_BANKS), .WORDS_PER_BANK(WORDS_PER_BANK)) array_i (
    .clk(clk), .rst_n(rst_n), .burn_en(burn_fire), .tgt_idx(tgt_idx),
    .tgt_bit(tgt_bit), .sense_byte(sense_byte), .sh_wr_en(sh_wr_en),
    .sh_idx(sh_idx), .sh_wdata(sh_wdata), .sh_rdata(sh_rdata)
  );
endmodule

// File: rtl/otp_fuse_chk.sv
`timescale 1ns/1ps
module otp_fuse_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       prog_go,
  input logic       sense_go,
  input logic       burn_fire,
  input logic       sense_fire,
  input logic [7:0] stat_bits
);
  // R3
  prog_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_go |=> busy);

  // R3
  burn_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burn_fire |=> (stat_bits[1] && !stat_bits[7]));

  // R7
  sense_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sense_fire |=> (stat_bits[0] && !stat_bits[7]));

  // R12
  no_start_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(prog_go || sense_go));

  // R12
  single_start_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_go, sense_go}));

  // R3
  busy_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(prog_go || sense_go));
endmodule

bind otp_fuse_ctrl otp_fuse_chk chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .prog_go(prog_go),
  .sense_go(sense_go), .burn_fire(burn_fire), .sense_fire(sense_fire),
  .stat_bits(stat_bits)
);

// File: tb/otp_fuse_ctrl_tb_top.sv
`timescale 1ns/1ps
module otp_fuse_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] prot_cfg;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        busy, irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  otp_fuse_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .prot_cfg(prot_cfg), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .busy(busy), .irq(irq)
  );

  // {read_check, req, addr, data}
  localparam int NV = 20;
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 4'd1,  12'h000, 8'h00},  // R1 control
    {1'b1, 4'd1,  12'h004, 8'h00},  // R1 status
    {1'b1, 4'd1,  12'h006, 8'h00},  // R1 error
    {1'b1, 4'd1,  12'h008, 8'h00},  // R1 sense data
    {1'b0, 4'd2,  12'h001, 8'hFF},  // R2 upper address
    {1'b1, 4'd2,  12'h001, 8'h3F},
    {1'b0, 4'd2,  12'h002, 8'hA5},  // R2 lower address
    {1'b1, 4'd2,  12'h002, 8'hA5},
    {1'b0, 4'd10, 12'h005, 8'hFF},  // R10 status mask width
    {1'b1, 4'd10, 12'h005, 8'h03},
    {1'b0, 4'd10, 12'h007, 8'hFF},  // R10 error mask width
    {1'b1, 4'd10, 12'h007, 8'hF4},
    {1'b0, 4'd10, 12'h005, 8'h00},
    {1'b0, 4'd10, 12'h007, 8'h00},
    {1'b0, 4'd4,  12'h003, 8'h3C},  // R4 key register
    {1'b1, 4'd4,  12'h003, 8'h3C},
    {1'b0, 4'd10, 12'h008, 8'h55},  // R10 sense data read-only
    {1'b1, 4'd10, 12'h008, 8'h00},
    {1'b0, 4'd8,  12'h805, 8'h9A},  // R8 shadow override
    {1'b1, 4'd8,  12'h805, 8'h9A}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    check(tag, d, exp);
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  function automatic int burn_len(input int l);
    return 16 * l + 16;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    // bank1 burn-protect, bank2 read-protect, bank3 override-protect
    prot_cfg = '0;
    prot_cfg[8*1 +: 8] = 8'h01;
    prot_cfg[8*2 +: 8] = 8'h02;
    prot_cfg[8*3 +: 8] = 8'h04;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy", {7'd0, busy}, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [24:0] v;
      logic [7:0]  d;
      v = VEC[i];
      if (v[24]) begin
        rd(v[19:8], d);
        n_tests++;
        if (d !== v[7:0]) begin
          n_fail++;
          $display("FAIL R%0d vector %0d: got %h expected %h", v[23:20], i, d, v[7:0]);
        end
      end else begin
        wr(v[19:8], v[7:0]);
      end
    end

    // R3 burn bank0 word 0x22 bit 5, length 0
    wr(12'h001, 8'h01); wr(12'h002, 8'h15); wr(12'h003, 8'hAA);
    wr(12'h000, 8'h01);
    wait_idle(n);
    check("R3 busy cycles L=0", 8'(n), 8'(burn_len(0)));
    rd_chk("R3 status done", 12'h004, 8'h02);
    rd_chk("R3 start self-clear", 12'h000, 8'h00);
    wr(12'h003, 8'h00);
    rd_chk("R3 shadow bit", 12'h822, 8'h20);

    // R7 sense the same byte
    wr(12'h000, 8'h08);
    wait_idle(n);
    check("R7 sense cycles", 8'(n), 8'd8);
    rd_chk("R7 sense data", 12'h008, 8'h20);
    rd_chk("R7 status", 12'h004, 8'h03);

    // R10 write-one-to-clear on status
    wr(12'h004, 8'h02);
    rd_chk("R10 status w1c", 12'h004, 8'h01);
    wr(12'h004, 8'h01);
    rd_chk("R10 status cleared", 12'h004, 8'h00);

    // R3 burn bit 0, length 2
    wr(12'h002, 8'h10); wr(12'h003, 8'hAA);
    wr(12'h000, 8'h21);
    wait_idle(n);
    check("R3 busy cycles L=2", 8'(n), 8'(burn_len(2)));
    rd_chk("R3 shadow two bits", 12'h822, 8'h21);
    wr(12'h003, 8'h00); wr(12'h004, 8'h02);

    // R4 wrong key
    wr(12'h002, 8'h11);
    wr(12'h000, 8'h01);
    check("R4 no cycle", {7'd0, busy}, 8'h00);
    rd_chk("R4 error bit", 12'h006, 8'h80);
    rd_chk("R4 nothing burned", 12'h822, 8'h21);
    wr(12'h006, 8'h80);
    rd_chk("R10 error w1c", 12'h006, 8'h00);

    // R5 burn-protected bank 1
    wr(12'h001, 8'h08); wr(12'h002, 8'h00); wr(12'h003, 8'hAA);
    wr(12'h000, 8'h01);
    check("R5 no cycle", {7'd0, busy}, 8'h00);
    rd_chk("R5 error bit", 12'h006, 8'h40);
    rd_chk("R5 nothing burned", 12'h900, 8'h00);
    wr(12'h006, 8'h40);

    // R6 disable-program bit
    wr(12'h001, 8'h01); wr(12'h002, 8'h17);
    wr(12'h000, 8'h81);
    check("R6 no cycle", {7'd0, busy}, 8'h00);
    rd_chk("R6 no error", 12'h006, 8'h00);
    rd_chk("R6 no done", 12'h004, 8'h00);
    rd_chk("R6 control readback", 12'h000, 8'h80);
    rd_chk("R6 nothing burned", 12'h822, 8'h21);
    wr(12'h000, 8'h00);

    // R7 sense on read-protected bank 2
    wr(12'h001, 8'h10);
    wr(12'h000, 8'h08);
    check("R7 protected no cycle", {7'd0, busy}, 8'h00);
    rd_chk("R7 sense error", 12'h006, 8'h04);
    wr(12'h006, 8'h04);

    // R9 shadow read on read-protected bank 2
    rd_chk("R9 masked data", 12'hA00, 8'h00);
    rd_chk("R9 error bit", 12'h006, 8'h10);
    wr(12'h006, 8'h10);

    // R8 override on override-protected bank 3
    wr(12'hB01, 8'h77);
    rd_chk("R8 override error", 12'h006, 8'h20);
    rd_chk("R8 shadow kept", 12'hB01, 8'h00);

    // R11 interrupt from masked error
    check("R11 irq masked", {7'd0, irq}, 8'h00);
    wr(12'h007, 8'h20);
    check("R11 irq error", {7'd0, irq}, 8'h01);
    wr(12'h007, 8'h00);
    check("R11 irq off", {7'd0, irq}, 8'h00);
    wr(12'h006, 8'h20);

    // R8 override leaves fuses intact
    wr(12'h822, 8'h00);
    rd_chk("R8 shadow replaced", 12'h822, 8'h00);
    wr(12'h001, 8'h01); wr(12'h002, 8'h10);
    wr(12'h000, 8'h08);
    wait_idle(n);
    rd_chk("R8 fuses unchanged", 12'h008, 8'h21);
    wr(12'h005, 8'h01);
    check("R11 irq status", {7'd0, irq}, 8'h01);
    wr(12'h005, 8'h00);
    wr(12'h004, 8'h01);

    // R12 start during a long burn, key still 0xAA
    wr(12'h002, 8'h11);
    wr(12'h000, 8'h71);
    wr(12'h000, 8'h08);
    wait_idle(n);
    check("R12 busy length", 8'(n + 1), 8'(burn_len(7)));
    rd_chk("R12 no sense done", 12'h004, 8'h02);
    rd_chk("R12 shadow burn bit", 12'h822, 8'h02);
    wr(12'h000, 8'h08);
    wait_idle(n);
    rd_chk("R12 fuse byte", 12'h008, 8'h23);

    finish_run();
  end
endmodule